// File: doc/BRIEF.md
# Bounds-Checked Byte-Addressed Video Memory

This block is a small video memory model built from bytes. One port writes on the clock edge. Two ports read a 32-bit little-endian word at any byte address without waiting for a clock. The storage size is a byte-count parameter. Write and read addresses are full 32-bit values, so the memory can sit behind a wide address bus with no narrowing logic in front of it.

Every access is checked against the storage size. The check never adds an offset to the incoming address, so an address near the top of the 32-bit space cannot wrap around and reach low memory. Writes are checked against the highest byte lane that is enabled. A halfword written at the very top of memory is therefore accepted whenever both of its bytes fit. A write that does not fit is dropped without any indication. A read that does not fit returns zero.

Each write carries four byte enables and a 32-bit bit mask. A stored bit changes only when its byte is enabled and its mask bit is set. An active-low reset clears the whole memory.

Top module: `vram_bounded`

## Requirements
- R1: Read port A returns, at an in-range byte address A, the byte at A on bits 7:0, A+1 on 15:8, A+2 on 23:16 and A+3 on 31:24.
- R2: Read port B has its own address and data. It follows the same rules as port A and does not depend on port A.
- R3: A read is in range only when its address is at most MEM_BYTES-4. At any other address, including those near 0xFFFF_FFFF, the read data is all zeros.
- R4: A write is committed at the rising clock edge while wr_en is high. A read of the written location shows the old data before that edge and the new data after it.
- R5: Byte enable bit k (wr_be[k]) selects byte A+k, which is data bits 8k+7:8k. Disabled bytes keep their value. For example, enables 4'b0011 write only the bytes at A and A+1.
- R6: Within an enabled byte, a stored bit takes the new data bit only where the matching wr_mask bit is 1. Elsewhere it keeps its old value.
- R7: A write is admitted only when A <= MEM_BYTES-1-h, where h is the index of the highest set bit in wr_be. With 4'b0011, a write at MEM_BYTES-2 is accepted. A write at MEM_BYTES-1 is rejected and leaves the containing word unchanged.
- R8: A write at an address near the top of the 32-bit space (for example 0xFFFF_FFFE) is rejected and never aliases onto low memory. Location 0 keeps its value.
- R9: A write that is not admitted changes no byte at all, including the enabled lanes that would fit.
- R10: While rst_n is low, the whole memory clears to zero, and both read ports return zero after reset.
- R11: A write with wr_be equal to 4'b0000 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the memory |
| wr_en | input | 1 | Write request |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write data, little-endian |
| wr_be | input | 4 | Byte-lane enables, bit k selects byte A+k |
| wr_mask | input | 32 | Bit mask applied inside the enabled lanes |
| rda_addr | input | 32 | Read port A byte address |
| rda_data | output | 32 | Read port A word, zero when out of range |
| rdb_addr | input | 32 | Read port B byte address |
| rdb_data | output | 32 | Read port B word, zero when out of range |

## Verification
A write and a combinational read can hit the same bytes in the same cycle. The read must show the old contents until the edge and the new contents after it.

The bench provokes this case by steering read port A to the address being written while the write is held, and steering port B to a random or overlapping address. It samples both ports shortly after the inputs change and again after the edge. It judges both samples against a byte-level model, which updates only at the edge. The boundary and wrap-around addresses get the same before-and-after treatment, so a rejected write is seen to leave the bytes it would have hit unchanged.

// File: rtl/vram_pkg.sv
package vram_pkg;

   localparam int unsigned LANES  = 4;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned WORD_W = LANES * LANE_W;

   typedef logic [LANE_W-1:0] byte_t;
   typedef logic [LANES-1:0]  lane_mask_t;
   typedef logic [1:0]        lane_idx_t;

   // index of the highest enabled lane, 0 when none is set
   function automatic lane_idx_t top_lane(input lane_mask_t be);
      lane_idx_t r;
      r = '0;
      for (int k = 0; k < LANES; k++) begin
         if (be[k]) r = lane_idx_t'(k);
      end
      return r;
   endfunction

endpackage

// File: rtl/vram_admit.sv
// Range admission: compares the raw address against per-lane constant limits
module vram_admit
   import vram_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 64,
   parameter int unsigned ADDR_W    = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  lane_mask_t        be,
   output logic              ok
);

   logic [LANES-1:0] fits;
   lane_idx_t        hi;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lim
         localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_BYTES - 1 - k);
         assign fits[k] = (addr <= LIMIT);
      end
   endgenerate

   always_comb begin
      hi = top_lane(be);
      ok = (|be) && fits[hi];
   end

endmodule

// File: rtl/vram_rd_port.sv
// Asynchronous bounds-checked word read
module vram_rd_port
   import vram_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 64,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned IDX_W     = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [MEM_BYTES-1:0][7:0]   mem,
   input  logic [ADDR_W-1:0]           addr,
   output logic [WORD_W-1:0]           data
);

   localparam logic [ADDR_W-1:0] TOP_WORD = ADDR_W'(MEM_BYTES - LANES);

   logic             in_rng;
   logic [IDX_W-1:0] base;

   vram_admit #(
      .MEM_BYTES(MEM_BYTES),
      .ADDR_W   (ADDR_W)
   ) i_admit (
      .addr(addr),
      .be  ({LANES{1'b1}}),
      .ok  (in_rng)
   );

   assign base = addr[IDX_W-1:0];

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [IDX_W-1:0] idx;
         assign idx = base + IDX_W'(k);
         assign data[k*LANE_W +: LANE_W] = in_rng ? mem[idx] : '0;
      end
   endgenerate

   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr > TOP_WORD) |-> (data == '0)); // R3

endmodule

// File: rtl/vram_store.sv
// Byte storage with masked, lane-enabled, admitted writes
module vram_store
   import vram_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 64,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned IDX_W     = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic                        wr_ok,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [WORD_W-1:0]           wr_data,
   input  lane_mask_t                  wr_be,
   input  logic [WORD_W-1:0]           wr_mask,
   output logic [MEM_BYTES-1:0][7:0]   mem_q
);

   logic [LANES-1:0]             hit;
   logic [LANES-1:0][IDX_W-1:0]  idx;
   byte_t [LANES-1:0]            nxt;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         byte_t d_k, m_k;
         assign d_k    = wr_data[k*LANE_W +: LANE_W];
         assign m_k    = wr_mask[k*LANE_W +: LANE_W];
         assign hit[k] = wr_en & wr_ok & wr_be[k];
         assign idx[k] = wr_addr[IDX_W-1:0] + IDX_W'(k);
         assign nxt[k] = (mem_q[idx[k]] & ~m_k) | (d_k & m_k);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else begin
         for (int k = 0; k < LANES; k++) begin
            if (hit[k]) mem_q[idx[k]] <= nxt[k];
         end
      end
   end

   AST_DROP_OOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ok) |=> $stable(mem_q)); // R9

   AST_NO_LANE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be == '0) |=> $stable(mem_q)); // R11

   AST_NO_ALIAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= ADDR_W'(MEM_BYTES)) |=> $stable(mem_q[0])); // R8

endmodule

// File: rtl/vram_bounded.sv
module vram_bounded
   import vram_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 64,
   parameter int unsigned ADDR_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic [LANES-1:0]    wr_be,
   input  logic [WORD_W-1:0]   wr_mask,
   input  logic [ADDR_W-1:0]   rda_addr,
   output logic [WORD_W-1:0]   rda_data,
   input  logic [ADDR_W-1:0]   rdb_addr,
   output logic [WORD_W-1:0]   rdb_data
);

   localparam int unsigned IDX_W = $clog2(MEM_BYTES);

   generate
      if (MEM_BYTES < LANES) begin : g_bad_size
         $error("vram_bounded: MEM_BYTES must hold at least one word");
      end
      if (ADDR_W < IDX_W + 1) begin : g_bad_addr
         $error("vram_bounded: ADDR_W too narrow for MEM_BYTES");
      end
   endgenerate

   logic                       wr_ok;
   logic [MEM_BYTES-1:0][7:0]  mem_q;

   vram_admit #(
      .MEM_BYTES(MEM_BYTES),
      .ADDR_W   (ADDR_W)
   ) i_wr_admit (
      .addr(wr_addr),
      .be  (wr_be),
      .ok  (wr_ok)
   );

   vram_store #(
      .MEM_BYTES(MEM_BYTES),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W)
   ) i_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_ok  (wr_ok),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .wr_be  (wr_be),
      .wr_mask(wr_mask),
      .mem_q  (mem_q)
   );

   vram_rd_port #(
      .MEM_BYTES(MEM_BYTES),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W)
   ) i_rd_a (
      .clk  (clk),
      .rst_n(rst_n),
      .mem  (mem_q),
      .addr (rda_addr),
      .data (rda_data)
   );

   vram_rd_port #(
      .MEM_BYTES(MEM_BYTES),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W)
   ) i_rd_b (
      .clk  (clk),
      .rst_n(rst_n),
      .mem  (mem_q),
      .addr (rdb_addr),
      .data (rdb_data)
   );

   AST_FULL_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be == 4'hF && wr_mask == '1 &&
       wr_addr <= ADDR_W'(MEM_BYTES - LANES) && rda_addr == wr_addr)
      |=> (!$stable(rda_addr) || rda_data == $past(wr_data))); // R4

endmodule

// File: tb/test_vram_bounded.sv
`timescale 1ns/1ps
module test_vram_bounded;

   localparam int unsigned N = 64;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [31:0] wr_addr, wr_data, wr_mask;
   logic [3:0]  wr_be;
   logic [31:0] rda_addr, rdb_addr;
   logic [31:0] rda_data, rdb_data;

   always #2.5 clk = ~clk;

   vram_bounded #(.MEM_BYTES(N), .ADDR_W(32)) i_vram_bounded (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .wr_mask(wr_mask),
      .rda_addr(rda_addr), .rda_data(rda_data),
      .rdb_addr(rdb_addr), .rdb_data(rdb_data)
   );

   logic [7:0] model [N];
   int checks = 0;
   int errors = 0;

   function automatic logic [31:0] exp_read(input logic [31:0] a);
      logic [31:0] w;
      w = '0;
      if ({32'd0, a} + 64'd3 <= 64'(N - 1))
         for (int k = 0; k < 4; k++) w[k*8 +: 8] = model[int'(a) + k];
      return w;
   endfunction

   function automatic bit exp_admit(input logic [31:0] a, input logic [3:0] be);
      int h;
      h = -1;
      for (int k = 0; k < 4; k++) if (be[k]) h = k;
      if (h < 0) return 1'b0;
      return ({32'd0, a} + 64'(h) <= 64'(N - 1));
   endfunction

   task automatic model_write(input logic [31:0] a, input logic [31:0] d,
                              input logic [3:0] be, input logic [31:0] m);
      if (exp_admit(a, be))
         for (int k = 0; k < 4; k++)
            if (be[k])
               model[int'(a) + k] = (model[int'(a) + k] & ~m[k*8 +: 8]) |
                                    (d[k*8 +: 8] & m[k*8 +: 8]);
   endtask

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   // one write cycle; reads sampled before and after the edge (R4)
   task automatic write_cycle(input logic [31:0] a, input logic [31:0] d,
                              input logic [3:0] be, input logic [31:0] m,
                              input logic [31:0] rb, input string req);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be; wr_mask = m;
      rda_addr = a; rdb_addr = rb;
      #1;
      check({req, " R4 before edge A"}, rda_data, exp_read(a));
      check({req, " R2 before edge B"}, rdb_data, exp_read(rb));
      @(posedge clk);
      model_write(a, d, be, m);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check({req, " R4 after edge A"}, rda_data, exp_read(a));
      check({req, " R2 after edge B"}, rdb_data, exp_read(rb));
   endtask

   task automatic read_pair(input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] ea, input logic [31:0] eb, input string req);
      @(negedge clk);
      rda_addr = a; rdb_addr = b;
      #1;
      check({req, " port A"}, rda_data, ea);
      check({req, " port B"}, rdb_data, eb);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] a, rb;
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) model[i] = '0;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      wr_be = '0; wr_mask = '0; rda_addr = '0; rdb_addr = '0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10: memory cleared
      for (int w = 0; w < N; w += 8)
         read_pair(32'(w), 32'(w + 4), 32'h0, 32'h0, "R10 reset clear");

      // R1 / R4: full word at 0 and at top word
      write_cycle(32'd0, 32'h8765_4321, 4'hF, '1, 32'd1, "R1 word@0");
      read_pair(32'd1, 32'd2, 32'h0087_6543, 32'h0000_8765, "R1 little-endian offsets");
      write_cycle(32'(N - 4), 32'hA1B2_C3D4, 4'hF, '1, 32'(N - 4), "R3 top word");
      check("R3 top word readable", rda_data, 32'hA1B2_C3D4);

      // R3: just past top word reads zero
      read_pair(32'(N - 3), 32'hFFFF_FFFE, 32'h0, 32'h0, "R3 oor read zero");

      // R7 / R9: full word at N-3 rejected, top word unchanged
      write_cycle(32'(N - 3), 32'h1111_2222, 4'hF, '1, 32'(N - 4), "R9 oor write");
      check("R9 top word unchanged", rdb_data, 32'hA1B2_C3D4);

      // R8: wrap-around address rejected, location 0 intact
      write_cycle(32'hFFFF_FFFE, 32'h5555_AAAA, 4'hF, '1, 32'd0, "R8 wrap");
      check("R8 no alias at 0", rdb_data, 32'h8765_4321);
      write_cycle(32'hFFFF_FFFD, 32'h0000_00EE, 4'h1, '1, 32'd0, "R8 wrap byte");
      check("R8 no alias byte", rdb_data, 32'h8765_4321);

      // R5 / R7: halfword at N-2 accepted, at N-1 rejected
      write_cycle(32'(N - 2), 32'h0000_7788, 4'b0011, '1, 32'(N - 4), "R7 hw N-2");
      check("R7 hw N-2 accepted", rdb_data, 32'h7788_C3D4);
      write_cycle(32'(N - 1), 32'h0000_99AA, 4'b0011, '1, 32'(N - 4), "R7 hw N-1");
      check("R7 hw N-1 rejected", rdb_data, 32'h7788_C3D4);

      // R5: only enabled lanes change
      write_cycle(32'd8, 32'hFFFF_FFFF, 4'b0101, '1, 32'd8, "R5 lanes");
      check("R5 lanes 0,2 only", rdb_data, 32'h00FF_00FF);

      // R6: bit mask
      write_cycle(32'd12, 32'hFFFF_FFFF, 4'hF, 32'h0F0F_00F0, 32'd12, "R6 mask");
      check("R6 masked bits", rdb_data, 32'h0F0F_00F0);

      // R11: no lanes
      write_cycle(32'd12, 32'h0000_0000, 4'h0, '1, 32'd12, "R11 be0");
      check("R11 unchanged", rdb_data, 32'h0F0F_00F0);

      // random mix
      for (int it = 0; it < 400; it++) begin
         case ($urandom % 8)
            6:       a = 32'(N - 4) + ($urandom % 4);
            7:       a = 32'hFFFF_FFFC + ($urandom % 4);
            default: a = $urandom % (N + 4);
         endcase
         rb = ($urandom % 2) ? a + ($urandom % 4) : ($urandom % (N + 4));
         write_cycle(a, $urandom, 4'($urandom), (($urandom % 3) == 0) ? $urandom : '1,
                     rb, exp_admit(a, 4'hF) ? "R1 R5 R6 random" : "R3 R7 R9 random");
      end

      finish_run();
   end

endmodule